// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port. It owns the output-data and output-enable registers that drive the pads, and it samples the pad inputs through a two-flop synchronizer. The synchronized value can be read back as the input register. Each pin has its own interrupt detector. A level bit and a polarity bit per pin select one of four trigger conditions. A per-pin source-select bit decides whether a detected condition is latched into the status register. A separate per-pin enable register decides whether a latched status bit drives the single port interrupt line.

Software uses a plain write strobe, a 12-bit address and 32-bit write data. Read data is a combinational function of the address. The eight registers sit 0x100 apart. At each register, offset +0x0 replaces the value, +0x4 sets the bits that are 1 in the write data, and +0x8 clears them. Single pins can therefore be changed without a read-modify-write. Status can only be cleared, and only through its clear alias. A detection that falls in the same cycle as a clear wins.

Top module: `gpio_irq_port`

## Requirements
- R1: After a cycle with rst_n low at a clock edge, every register reads 0, and pin_out, pin_oe and irq are 0.
- R2: Register index k (address bits [10:8]) is at address k*0x100. The indices are: 0 output data, 1 input data, 2 output enable, 3 source select, 4 line enable, 5 level select, 6 polarity, 7 status. A write at +0x0 replaces the register, +0x4 ORs in the write data, and +0x8 clears the bits that are 1 in the write data. A read at the base address returns the register.
- R3: pin_out equals the output-data register and pin_oe equals the output-enable register. An output-enable bit of 1 marks that pin as an output.
- R4: The input-data register returns pin_in delayed by two clock edges. Writes to it through any alias have no effect.
- R5: For a selected pin, the code {polarity, level} picks the trigger condition, applied to the synchronized input: 00 falling edge, 01 low level, 10 rising edge, 11 high level. On a detection, the status bit is 1 after the third clock edge following the pin change.
- R6: A pin whose source-select bit is 0 never sets its status bit.
- R7: A status bit is cleared only by writing 1 to that bit at the status clear alias (+0x8). Writes at the status base or set alias leave status unchanged.
- R8: In level mode, a status bit is set again on every cycle in which the level persists, so clearing it while the level is held has no lasting effect. Once the level is gone, a clear takes effect.
- R9: When a clear of a status bit and a detection for the same pin occur at the same edge, the bit stays 1.
- R10: irq is 1 exactly when some bit is 1 in both status and line enable. A bit with line enable 0 still latches in status.
- R11: An address with a low nibble other than 0x0, 0x4 or 0x8, or with any of bits [7:4] or [11] set, is ignored on write and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte address of register and alias |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Asynchronous pad inputs |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Pad output enables, 1 = drive |
| irq | output | 1 | Port interrupt line |

## Verification
Directed sequences drive a single pin in each of the four trigger modes. The rising and falling cases show that only the configured transition latches status, and that the condition is taken from the delayed, synchronized sample. A held high level combined with clears separates a lost event from a correct re-set, and the same-edge clear shows which side of the collision wins. Toggling a pin whose source select is off, and writing at the status base and set aliases, show that nothing latches without permission. Random traffic over all aliases, including invalid offsets, runs with random pin activity and is compared every cycle against a bench reference model. This traffic mixes all four modes on many pins at once, so interaction between pins and between bus writes and detections is exercised as well.

// File: rtl/gpio_port_pkg.sv
// Package: shared constants and types for the GPIO interrupt port.
// Assumes eight registers addressed by a 3-bit index.
package gpio_port_pkg;

    localparam int REG_CNT   = 8;
    localparam int REG_IDX_W = 3;

    // Register indices; index order fixes the address map.
    localparam int IDX_DOUT = 0;
    localparam int IDX_DIN  = 1;
    localparam int IDX_OE   = 2;
    localparam int IDX_SEL  = 3;
    localparam int IDX_EN   = 4;
    localparam int IDX_LVL  = 5;
    localparam int IDX_POL  = 6;
    localparam int IDX_STAT = 7;

    // Alias offsets within a register slot.
    localparam logic [3:0] OFS_WRITE = 4'h0;
    localparam logic [3:0] OFS_SET   = 4'h4;
    localparam logic [3:0] OFS_CLEAR = 4'h8;

    // Trigger mode encoded as {polarity, level}.
    typedef enum logic [1:0] {
        TRIG_FALL = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_mode_e;

endpackage

// File: rtl/gpio_addr_decode.sv
// Module: address decoder for the register file.
// Splits a byte address into register index and alias operation.
// Assumes AW covers the index field; higher address bits must be zero.
module gpio_addr_decode
    import gpio_port_pkg::*;
#(
    parameter int AW      = 12,
    parameter int IDX_LSB = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        addr,
    input  logic                 wr,
    output logic                 valid,
    output logic [REG_IDX_W-1:0] idx,
    output logic                 do_wr,
    output logic                 do_set,
    output logic                 do_clr
);
    localparam int IDX_MSB = IDX_LSB + REG_IDX_W - 1;

    logic       upper_ok;
    logic       mid_ok;
    logic [3:0] sub;

    // Upper bits above the index must be zero, when present.
    generate
        if (AW > IDX_MSB + 1) begin : g_upper
            assign upper_ok = (addr[AW-1:IDX_MSB+1] == '0);
        end else begin : g_noupper
            assign upper_ok = 1'b1;
        end
    endgenerate

    assign mid_ok = (addr[IDX_LSB-1:4] == '0);
    assign sub    = addr[3:0];
    assign idx    = addr[IDX_MSB:IDX_LSB];

    // Classify the alias offset and qualify with the write strobe.
    always_comb begin
        valid  = upper_ok && mid_ok &&
                 (sub == OFS_WRITE || sub == OFS_SET || sub == OFS_CLEAR);
        do_wr  = wr && valid && (sub == OFS_WRITE);
        do_set = wr && valid && (sub == OFS_SET);
        do_clr = wr && valid && (sub == OFS_CLEAR);
    end

    AST_DEC_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_wr, do_set, do_clr}) && ((do_wr || do_set || do_clr) -> valid)); // R11

endmodule

// File: rtl/gpio_in_sync.sv
// Module: multi-stage input synchronizer.
// Assumes pin inputs are asynchronous; output is the last stage.
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= (s == 0) ? d : stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_trig_detect.sv
// Module: per-pin trigger detector.
// Compares the synchronized input with its previous sample and applies
// the {polarity, level} mode. Output is a per-cycle detection pulse,
// gated by the source-select bit.
module gpio_trig_detect
    import gpio_port_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_s,
    input  logic [W-1:0] sel,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] pol,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_q;

    // Keep the previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_s;
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            trig_mode_e mode;
            assign mode = trig_mode_e'({pol[i], lvl[i]});
            // Evaluate the configured condition for one pin.
            always_comb begin
                unique case (mode)
                    TRIG_FALL: hit[i] = sel[i] & ~pin_s[i] &  prev_q[i];
                    TRIG_LOW:  hit[i] = sel[i] & ~pin_s[i];
                    TRIG_RISE: hit[i] = sel[i] &  pin_s[i] & ~prev_q[i];
                    default:   hit[i] = sel[i] &  pin_s[i];
                endcase
            end
        end
    endgenerate

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit & ~lvl & ~(pin_s ^ prev_q)) == '0)); // R5

endmodule

// File: rtl/gpio_ctl_reg.sv
// Module: one control register with write, set and clear aliases.
// Assumes at most one of wr/set/clr is active per cycle.
module gpio_ctl_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         set,
    input  logic         clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Apply the alias operation selected this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (wr)  q <= wdata;
        else if (set) q <= q | wdata;
        else if (clr) q <= q & ~wdata;
    end

endmodule

// File: rtl/gpio_irq_port.sv
// Module: GPIO port top level with per-pin interrupt detection.
// Holds the register file, synchronizes pin inputs, latches status and
// drives one interrupt line. Status is clear-only from the bus; a hardware
// detection in the same cycle takes priority over a clear.
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int AW          = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq
);
    logic                 dec_valid;
    logic [REG_IDX_W-1:0] dec_idx;
    logic                 do_wr, do_set, do_clr;
    logic [REG_CNT-1:0]   reg_hit;
    logic [NPINS-1:0]     reg_q [REG_CNT];
    logic [NPINS-1:0]     pin_sync;
    logic [NPINS-1:0]     det_hit;
    logic [NPINS-1:0]     stat_q;
    logic [NPINS-1:0]     clr_mask;
    logic                 oe_touch;

    gpio_addr_decode #(.AW(AW), .IDX_LSB(8)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .valid  (dec_valid),
        .idx    (dec_idx),
        .do_wr  (do_wr),
        .do_set (do_set),
        .do_clr (do_clr)
    );

    // One-hot register select from a valid address.
    always_comb begin
        reg_hit = '0;
        if (dec_valid) reg_hit[dec_idx] = 1'b1;
    end

    gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    generate
        for (genvar r = 0; r < REG_CNT; r++) begin : g_reg
            if (r == IDX_DIN) begin : g_din
                assign reg_q[r] = pin_sync;
            end else if (r == IDX_STAT) begin : g_stat
                assign reg_q[r] = stat_q;
            end else begin : g_ctl
                gpio_ctl_reg #(.W(NPINS)) u_reg (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .wr    (do_wr  & reg_hit[r]),
                    .set   (do_set & reg_hit[r]),
                    .clr   (do_clr & reg_hit[r]),
                    .wdata (bus_wdata),
                    .q     (reg_q[r])
                );
            end
        end
    endgenerate

    gpio_trig_detect #(.W(NPINS)) u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_s (pin_sync),
        .sel   (reg_q[IDX_SEL]),
        .lvl   (reg_q[IDX_LVL]),
        .pol   (reg_q[IDX_POL]),
        .hit   (det_hit)
    );

    assign clr_mask = (do_clr && reg_hit[IDX_STAT]) ? bus_wdata : '0;

    // Latch status: clear via alias, detection has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | det_hit;
    end

    assign bus_rdata = dec_valid ? reg_q[dec_idx] : '0;
    assign pin_out   = reg_q[IDX_DOUT];
    assign pin_oe    = reg_q[IDX_OE];
    assign irq       = |(stat_q & reg_q[IDX_EN]);
    assign oe_touch  = bus_wr && dec_valid && (dec_idx == REG_IDX_W'(IDX_OE));

    AST_STAT_SET_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~$past(stat_q) & ~$past(reg_q[IDX_SEL])) == '0)); // R6

    AST_STAT_CLR_ONLY_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_q) & ~stat_q & ~$past(clr_mask)) == '0)); // R7

    AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(oe_touch) |-> $stable(pin_oe)); // R3

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(reg_q[IDX_SEL] & reg_q[IDX_LVL] & reg_q[IDX_POL] & pin_sync) & ~stat_q) == '0)); // R8

endmodule

// File: tb/gpio_irq_port_bench.sv
`timescale 1ns/10ps
module gpio_irq_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;
    logic [31:0] cur_pins = '0;

    // reference model state
    logic [31:0] m_reg [8];
    logic [31:0] m_s1, m_s2, m_prev;

    always #4 clk = ~clk;

    gpio_irq_port u_gpio_irq_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic bit addr_ok(logic [11:0] a);
        return (a[11] == 1'b0) && (a[7:4] == 4'h0) &&
               (a[3:0] == 4'h0 || a[3:0] == 4'h4 || a[3:0] == 4'h8);
    endfunction

    // trigger conditions from R5: {pol,lvl} 00 fall, 01 low, 10 rise, 11 high
    function automatic logic [31:0] exp_det(logic [31:0] sel, logic [31:0] lvl,
                                            logic [31:0] pol, logic [31:0] s,
                                            logic [31:0] p);
        return sel & (( pol &  lvl &  s) | ( pol & ~lvl &  s & ~p) |
                      (~pol &  lvl & ~s) | (~pol & ~lvl & ~s &  p));
    endfunction

    // reference model update at each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) m_reg[k] = '0;
            m_s1 = '0; m_s2 = '0; m_prev = '0;
        end else begin
            logic [31:0] det, clr;
            logic [2:0]  ix;
            det = exp_det(m_reg[3], m_reg[5], m_reg[6], m_s2, m_prev);
            ix  = bus_addr[10:8];
            clr = (bus_wr && addr_ok(bus_addr) && ix == 3'd7 && bus_addr[3:0] == 4'h8)
                  ? bus_wdata : '0;
            if (bus_wr && addr_ok(bus_addr) && ix != 3'd1 && ix != 3'd7) begin
                case (bus_addr[3:0])
                    4'h0:    m_reg[ix] = bus_wdata;
                    4'h4:    m_reg[ix] = m_reg[ix] | bus_wdata;
                    default: m_reg[ix] = m_reg[ix] & ~bus_wdata;
                endcase
            end
            m_reg[7] = (m_reg[7] & ~clr) | det;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
            m_reg[1] = m_s2;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.2;
        d = bus_rdata;
    endtask

    // compare all outputs to the model (bus_wr must be 0)
    task automatic verify(string tag);
        logic [31:0] d;
        for (int k = 0; k < 8; k++) begin
            rd(12'(k * 256), d);
            chk(tag, d, m_reg[k]);
        end
        chk(tag, pin_out, m_reg[0]);
        chk(tag, pin_oe, m_reg[2]);
        chk(tag, {31'd0, irq}, {31'd0, |(m_reg[7] & m_reg[4])});
    endtask

    task automatic tick(bit we, logic [11:0] a, logic [31:0] d, logic [31:0] p, string tag);
        @(negedge clk);
        bus_wr = 1'b0;
        verify(tag);
        bus_wr = we; bus_addr = a; bus_wdata = d; pin_in = p; cur_pins = p;
    endtask

    task automatic idle(int n, string tag);
        for (int k = 0; k < n; k++) tick(1'b0, 12'h0, 32'h0, cur_pins, tag);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
        tick(1'b1, a, d, cur_pins, tag);
        idle(1, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int seed;
        seed = $urandom(32'h5EED_1234);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        idle(1, "R1");
        rd(12'h700, d); chk("R1 status", d, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);
        chk("R1 oe", pin_oe, 32'h0);

        // R3 / R2: outputs and aliases
        wr(12'h200, 32'h0000_F0F0, "R3");
        wr(12'h004, 32'h0000_00FF, "R2");
        chk("R3 oe", pin_oe, 32'h0000_F0F0);
        chk("R3 out", pin_out, 32'h0000_00FF);
        wr(12'h208, 32'h0000_F000, "R2");
        rd(12'h200, d); chk("R2 clear alias", d, 32'h0000_00F0);

        // R11: invalid offsets ignored
        wr(12'h20C, 32'hFFFF_FFFF, "R11");
        wr(12'h210, 32'hFFFF_FFFF, "R11");
        wr(12'hA00, 32'hFFFF_FFFF, "R11");
        rd(12'h200, d); chk("R11 oe kept", d, 32'h0000_00F0);
        rd(12'h20C, d); chk("R11 read zero", d, 32'h0);

        // R5: rising edge on pin 5, enabled
        wr(12'h304, 32'h20, "R5"); wr(12'h604, 32'h20, "R5"); wr(12'h404, 32'h20, "R10");
        tick(1'b0, 12'h0, 32'h0, 32'h20, "R5");
        idle(2, "R5");
        rd(12'h700, d); chk("R5 rise not yet", d, 32'h0);
        idle(1, "R5");
        rd(12'h700, d); chk("R5 rise latched", d, 32'h20);
        chk("R10 irq", {31'd0, irq}, 32'h1);

        // R4: input register follows pins, writes ignored
        wr(12'h100, 32'h0, "R4"); wr(12'h108, 32'hFFFF_FFFF, "R4");
        rd(12'h100, d); chk("R4 din", d, 32'h20);

        // R7: base and set alias on status ignored
        wr(12'h700, 32'h0, "R7"); wr(12'h704, 32'hFFFF_FFFF, "R7");
        rd(12'h700, d); chk("R7 status kept", d, 32'h20);
        wr(12'h708, 32'h20, "R7");
        rd(12'h700, d); chk("R7 cleared", d, 32'h0);
        chk("R10 irq low", {31'd0, irq}, 32'h0);

        // R9 / R8: high level mode, clear while held
        wr(12'h504, 32'h20, "R8");
        idle(1, "R8");
        tick(1'b1, 12'h708, 32'h20, cur_pins, "R9");
        idle(1, "R9");
        rd(12'h700, d); chk("R9 detection wins", d, 32'h20);
        idle(3, "R8");
        rd(12'h700, d); chk("R8 level held", d, 32'h20);
        tick(1'b0, 12'h0, 32'h0, 32'h0, "R8");
        idle(3, "R8");
        wr(12'h708, 32'h20, "R8");
        rd(12'h700, d); chk("R8 clear after level gone", d, 32'h0);

        // R6: pin 9 toggled with select off, rising mode
        wr(12'h604, 32'h200, "R6");
        tick(1'b0, 12'h0, 32'h0, 32'h200, "R6"); idle(3, "R6");
        tick(1'b0, 12'h0, 32'h0, 32'h0, "R6"); idle(3, "R6");
        rd(12'h700, d); chk("R6 no latch", d, 32'h0);

        // R5: falling edge on pin 2, line enable off (R10 still latches)
        wr(12'h304, 32'h4, "R5");
        tick(1'b0, 12'h0, 32'h0, 32'h4, "R5"); idle(3, "R5");
        rd(12'h700, d); chk("R5 no fall on rise", d, 32'h0);
        tick(1'b0, 12'h0, 32'h0, 32'h0, "R5"); idle(3, "R5");
        rd(12'h700, d); chk("R5 fall latched", d, 32'h4);
        chk("R10 masked irq", {31'd0, irq}, 32'h0);

        // random traffic compared every cycle against the model
        for (int n = 0; n < 3000; n++) begin
            logic [11:0] a;
            logic [31:0] wd, p;
            logic [3:0]  sub;
            case ($urandom % 4)
                0: sub = 4'h0; 1: sub = 4'h4; 2: sub = 4'h8;
                default: sub = (($urandom % 3) == 0) ? 4'hC : 4'h8;
            endcase
            a  = {1'b0, 3'($urandom % 8), 4'h0, sub};
            if (($urandom % 20) == 0) a[6] = 1'b1;
            wd = $urandom & $urandom;
            p  = cur_pins ^ ($urandom & $urandom & $urandom);
            tick(($urandom % 3) == 0, a, wd, p, "R2 R5 R10 random");
        end
        idle(2, "R2");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule